// File: doc/BRIEF.md
# Dual-Controller Vectored Interrupt Resolver

This block merges the request lines of two interrupt controllers, each with `NSRC` level-sensitive sources, into one prioritised answer. Every controller owns a table of `NSLOT` vector slots. A slot holds an enable bit and a source index. Software fills the slots through a one-cycle write strobe. A source that sits in an enabled slot is vectored. Any other active source is unvectored.

The block registers an 11-bit vector word that names the winning interrupt, and an IRQ line to the processor. Both controllers read this one word, so reading it through either controller's register address returns the same value. A vectored winner sets bit 8 and carries its combined source number in the low bits. An unvectored winner sets bit 9 when it comes from the first controller and bit 10 when it comes from the second. Bit 8 lets source zero be told apart from the idle value 0x000.

The configuration port has no back-pressure. A write strobe is accepted in every cycle in which `cfg_we` is high, and no ready signal exists. The request lines are plain level inputs and are sampled at every clock.

Top module: `vir_resolver`

## Requirements
- R1: When no request is active on either controller, `vec_word` reads 0x000 one clock later.
- R2: A vectored winner yields `vec_word` = 0x100 | (c*NSRC + s). Here c is 0 for the first controller and 1 for the second, and s is the slot's source index. At most one of bits 10..8 is ever set.
- R3: A slot matches only when its enable bit is 1 and its source request is high. Among matching slots of one controller, the lowest slot index wins.
- R4: A matching slot on the first controller beats every matching slot on the second controller.
- R5: Whenever any slot matches, the result is vectored, whatever unvectored requests are also active.
- R6: With no slot matching and any first-controller request high, `vec_word` = 0x200 | i, where i is the lowest active first-controller source.
- R7: With no slot matching and no first-controller request, any second-controller request yields `vec_word` = 0x400 | (NSRC + j), where j is the lowest active second-controller source.
- R8: `vec_word` and `irq` are registered. A request change is visible after the next rising edge. A slot write takes effect at its own edge and shows on the outputs one edge later.
- R9: The asynchronous active-low reset `rst_n` clears every slot enable and forces `vec_word` to 0x000 and `irq` to 0.
- R10: `irq` is 1 exactly when `vec_word` is non-zero.
- R11: A write with `cfg_we`=1 loads slot `cfg_slot` of controller `cfg_ctl` (0 = first, 1 = second) with enable `cfg_en` and source `cfg_src`. Writing `cfg_en`=0 removes that slot from matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_ctl | input | 1 | Controller select for the write |
| cfg_slot | input | $clog2(NSLOT) | Slot index to write |
| cfg_en | input | 1 | Enable bit to store |
| cfg_src | input | $clog2(NSRC) | Source index to store |
| req_a | input | NSRC | First controller request levels |
| req_b | input | NSRC | Second controller request levels |
| vec_word | output | 11 | Shared vector word |
| irq | output | 1 | Interrupt to the processor |

## Verification
The bench builds the block with NSRC=8 and NSLOT=4. This makes every one of the 65,536 joint request patterns of the two controllers reachable in one run, against a fixed slot table that mixes enabled and disabled slots and places sources in non-monotonic order. Single-source sweeps cover every unvectored number on both controllers. Directed writes then reorder, disable and add slots, and check the one-edge write latency and the reset that clears the table.

// File: rtl/vir_pkg.sv
package vir_pkg;
  localparam int WORD_W   = 11;
  localparam int LOW_W    = 8;
  localparam int FLAG_VEC = 8;
  localparam int FLAG_UA  = 9;
  localparam int FLAG_UB  = 10;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_VEC  = 2'd1,
    K_UA   = 2'd2,
    K_UB   = 2'd3
  } kind_e;
endpackage

// File: rtl/vir_slot_table.sv
module vir_slot_table #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  localparam int SRCW  = $clog2(NSRC),
  localparam int SLOTW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic [SLOTW-1:0] wr_slot,
  input  logic             wr_enable,
  input  logic [SRCW-1:0]  wr_src,
  input  logic [NSRC-1:0]  req,
  output logic             hit,
  output logic [SRCW-1:0]  hit_src
);
  logic [NSLOT-1:0] en_q;
  logic [SRCW-1:0]  src_q [NSLOT];
  logic [NSLOT-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < NSLOT; i++) src_q[i] <= '0;
    end else if (wr_go) begin
      en_q[wr_slot]  <= wr_enable;
      src_q[wr_slot] <= wr_src;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_match
    assign match[g] = en_q[g] & req[src_q[g]];
  end

  // lowest slot index takes priority
  always_comb begin
    hit     = |match;
    hit_src = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (match[i]) hit_src = src_q[i];
    end
  end

  // R3: a reported match always points at a raised request
  a_r3_hit_is_live: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> req[hit_src]);
  // R3: no requests means no match
  a_r3_quiet_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !hit);
endmodule

// File: rtl/vir_lowest.sv
module vir_lowest #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vir_resolver.sv
module vir_resolver #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  localparam int SRCW  = $clog2(NSRC),
  localparam int SLOTW = $clog2(NSLOT),
  localparam int NUMW  = $clog2(2 * NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_ctl,
  input  logic [SLOTW-1:0] cfg_slot,
  input  logic             cfg_en,
  input  logic [SRCW-1:0]  cfg_src,
  input  logic [NSRC-1:0]  req_a,
  input  logic [NSRC-1:0]  req_b,
  output logic [10:0]      vec_word,
  output logic             irq
);
  import vir_pkg::*;

  logic [1:0][NSRC-1:0] req_all;
  logic [1:0]           hit;
  logic [SRCW-1:0]      hit_src [2];
  logic [1:0]           any;
  logic [SRCW-1:0]      low [2];

  assign req_all[0] = req_a;
  assign req_all[1] = req_b;

  for (genvar c = 0; c < 2; c++) begin : g_ctl
    vir_slot_table #(.NSRC(NSRC), .NSLOT(NSLOT)) u_tab (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_go     (cfg_we && (cfg_ctl == c[0])),
      .wr_slot   (cfg_slot),
      .wr_enable (cfg_en),
      .wr_src    (cfg_src),
      .req       (req_all[c]),
      .hit       (hit[c]),
      .hit_src   (hit_src[c])
    );
    vir_lowest #(.W(NSRC)) u_low (
      .vec (req_all[c]),
      .any (any[c]),
      .idx (low[c])
    );
  end

  function automatic logic [NUMW-1:0] f_num(input logic c, input logic [SRCW-1:0] s);
    f_num = (c ? NUMW'(NSRC) : NUMW'(0)) + NUMW'(s);
  endfunction

  kind_e             kind;
  logic [NUMW-1:0]   num;
  logic [WORD_W-1:0] word_d;
  logic              irq_d;

  always_comb begin
    kind = K_IDLE;
    num  = '0;
    if (hit[0]) begin
      kind = K_VEC; num = f_num(1'b0, hit_src[0]);
    end else if (hit[1]) begin
      kind = K_VEC; num = f_num(1'b1, hit_src[1]);
    end else if (any[0]) begin
      kind = K_UA;  num = f_num(1'b0, low[0]);
    end else if (any[1]) begin
      kind = K_UB;  num = f_num(1'b1, low[1]);
    end
  end

  always_comb begin
    word_d = '0;
    word_d[LOW_W-1:0] = LOW_W'(num);
    case (kind)
      K_VEC:   word_d[FLAG_VEC] = 1'b1;
      K_UA:    word_d[FLAG_UA]  = 1'b1;
      K_UB:    word_d[FLAG_UB]  = 1'b1;
      default: word_d = '0;
    endcase
    irq_d = (kind != K_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_word <= '0;
      irq      <= 1'b0;
    end else begin
      vec_word <= word_d;
      irq      <= irq_d;
    end
  end

  // R1: idle inputs give an idle word
  a_r1_idle_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req_a == '0 && req_b == '0) |=> (vec_word == 11'h000));
  // R2: flag field is one-hot or empty
  a_r2_flag_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_word[10:8]));
  // R5: a slot match forces a vectored result
  a_r5_vec_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> vec_word[FLAG_VEC]);
  // R7: second-controller unvectored result blocked by any first-controller request
  a_r7_b_after_a: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_a) |=> !vec_word[FLAG_UB]);
  // R6: lowest-source finder points at a raised line
  a_r6_lowest_live: assert property (@(posedge clk) disable iff (!rst_n)
    any[0] |-> req_a[low[0]]);
  // R10: irq tracks a non-zero word
  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec_word != 11'h000));
endmodule

// File: tb/sim_vir_resolver.sv
`timescale 1ns/1ps
module sim_vir_resolver;
  localparam int NSRC  = 8;
  localparam int NSLOT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_ctl = 1'b0;
  logic [1:0] cfg_slot = '0;
  logic       cfg_en = 1'b0;
  logic [2:0] cfg_src = '0;
  logic [7:0] req_a = '0;
  logic [7:0] req_b = '0;
  logic [10:0] vec_word;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic m_en [2][NSLOT];
  int   m_src [2][NSLOT];

  always #4 clk = ~clk;

  vir_resolver #(.NSRC(NSRC), .NSLOT(NSLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctl(cfg_ctl),
    .cfg_slot(cfg_slot), .cfg_en(cfg_en), .cfg_src(cfg_src),
    .req_a(req_a), .req_b(req_b), .vec_word(vec_word), .irq(irq)
  );

  function automatic logic [10:0] model(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    for (int c = 0; c < 2; c++) begin
      r = (c == 0) ? a : b;
      for (int s = 0; s < NSLOT; s++)
        if (m_en[c][s] && r[m_src[c][s]]) return 11'h100 | 11'(c * NSRC + m_src[c][s]);
    end
    for (int i = 0; i < NSRC; i++) if (a[i]) return 11'h200 | 11'(i);
    for (int i = 0; i < NSRC; i++) if (b[i]) return 11'h400 | 11'(NSRC + i);
    return 11'h000;
  endfunction

  task automatic chk(input string tag, input logic [10:0] exp);
    checks++;
    if (vec_word !== exp || irq !== (exp != 0)) begin
      errors++;
      $display("FAIL %s: vec_word=%h irq=%b expected vec_word=%h irq=%b",
               tag, vec_word, irq, exp, (exp != 0));
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input string tag);
    req_a = a; req_b = b;
    @(posedge clk); @(negedge clk);
    chk(tag, model(a, b));
  endtask

  task automatic wr(input logic c, input int s, input logic e, input int src);
    cfg_we = 1'b1; cfg_ctl = c; cfg_slot = 2'(s); cfg_en = e; cfg_src = 3'(src);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    m_en[c][s] = e; m_src[c][s] = src;
  endtask

  function automatic string tag_of(input logic [10:0] w);
    if (w[8]) return (w[7:0] >= NSRC) ? "R4/R5 vectored b" : "R3/R5 vectored a";
    if (w[9]) return "R6 unvectored a";
    if (w[10]) return "R7 unvectored b";
    return "R1 idle";
  endfunction

  initial begin
    for (int c = 0; c < 2; c++) for (int s = 0; s < NSLOT; s++) begin
      m_en[c][s] = 1'b0; m_src[c][s] = 0;
    end
    req_a = 8'hFF;
    #3;
    chk("R9 reset output", 11'h000);
    repeat (2) @(negedge clk);
    chk("R9 held in reset", 11'h000);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 enables cleared", 11'h200);

    apply(8'h00, 8'h00, "R1 idle");
    for (int i = 0; i < NSRC; i++) apply(8'(1 << i), 8'h00, "R6 single a");
    for (int i = 0; i < NSRC; i++) apply(8'h00, 8'(1 << i), "R7 single b");
    for (int p = 0; p < 256; p++) apply(8'(p), 8'(255 - p), "R6 lowest a");
    for (int p = 0; p < 256; p++) apply(8'h00, 8'(p), "R7 lowest b");

    // R11 table programming
    wr(1'b0, 0, 1'b1, 5); wr(1'b0, 1, 1'b1, 2); wr(1'b0, 2, 1'b1, 7); wr(1'b0, 3, 1'b0, 0);
    wr(1'b1, 0, 1'b1, 1); wr(1'b1, 1, 1'b1, 6); wr(1'b1, 2, 1'b0, 3); wr(1'b1, 3, 1'b1, 0);
    apply(8'h24, 8'h00, "R3 slot0 beats slot1");
    apply(8'h84, 8'h00, "R3 slot1 beats slot2");
    apply(8'h01, 8'h00, "R3 disabled slot ignored");
    apply(8'h04, 8'h02, "R4 first ctl wins");
    apply(8'h01, 8'h40, "R5 vectored b over unvectored a");
    apply(8'h00, 8'h09, "R2 vectored b number");

    for (int p = 0; p < 65536; p++) begin
      logic [10:0] e;
      e = model(8'(p), 8'(p >> 8));
      apply(8'(p), 8'(p >> 8), tag_of(e));
    end

    wr(1'b0, 0, 1'b0, 5);
    apply(8'h20, 8'h00, "R11 disabled slot unvectored");
    wr(1'b0, 0, 1'b1, 5);
    apply(8'h20, 8'h00, "R11 re-enabled slot");

    // R8 request latency
    apply(8'h00, 8'h00, "R8 base");
    req_a = 8'h10;
    #1 chk("R8 before edge", 11'h000);
    @(posedge clk); @(negedge clk);
    chk("R8 after edge", 11'h204);

    // R8 write latency
    apply(8'h00, 8'h10, "R8 write base");
    cfg_we = 1'b1; cfg_ctl = 1'b1; cfg_slot = 2'd0; cfg_en = 1'b1; cfg_src = 3'd4;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0; m_en[1][0] = 1'b1; m_src[1][0] = 4;
    chk("R8 write edge old value", 11'h40C);
    @(posedge clk); @(negedge clk);
    chk("R8 write visible", 11'h10C);

    // R9 reset mid-run
    req_a = 8'h20;
    rst_n = 1'b0;
    #1 chk("R9 async clear", 11'h000);
    @(negedge clk); rst_n = 1'b1;
    for (int c = 0; c < 2; c++) for (int s = 0; s < NSLOT; s++) m_en[c][s] = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 slots cleared", 11'h205);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule